// File: doc/BRIEF.md
# Write-Once Block Memory Controller

This block holds a small user memory that can be programmed only once per 4-byte block. A write request names a block and carries a full 32-bit word. When the block is still blank, the word is stored and a write-protect flag for that block is set in the same clock edge. From then on the block is locked and needs no separate lock command. A later write to that block changes nothing and is answered with a "protected" status. A write that names a block past the end of user memory is also refused, with its own status code.

User memory covers byte addresses 0x00 to 0x17 of a linear address space. Any address above that range belongs to other register space and is not served here. Reads are byte-wide and registered: the byte shows on the output one cycle after its address is presented. The per-block protection vector is visible at all times, so a host can tell which blocks are still blank without reading them.

The storage is plain flip-flops. Reset returns every byte to 00h and clears every protection bit, which lets the model be simulated over and over.

Top module: `otp_block_mem`

## Requirements
- R1: After reset every user byte reads 00h, every bit of `prot_map` is 0 and `wr_resp_valid` is 0.
- R2: For an address in 0x00..0x17 held on `rd_addr`, `rd_data` shows the stored byte after the next rising clock edge and `rd_err` is 0.
- R3: For an address of 0x18 or above, `rd_data` is 00h and `rd_err` is 1 after the next rising clock edge.
- R4: A write to an unprotected block n (0..5) stores `wr_data` so that byte address 4n+k holds `wr_data[8k+7:8k]`, and it answers with status 00.
- R5: A successful write to block n sets bit n of `prot_map`. A protection bit is never cleared except by reset.
- R6: A write to a block whose protection bit is set answers with status 01 and leaves all memory bytes and `prot_map` unchanged.
- R7: A write whose block index is 6 or more answers with status 10 and leaves all memory bytes and `prot_map` unchanged.
- R8: Each cycle in which `wr_valid` is high produces exactly one cycle of `wr_resp_valid` in the following cycle, with `wr_status` valid in that cycle. The value 11 is never reported.
- R9: Any 32-bit pattern, including all zeros, is a valid first write. It is stored as given and it locks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request strobe, one cycle per request |
| wr_blk | input | 8 | Target block index |
| wr_data | input | 32 | Block word; bits 7:0 go to the lowest address |
| wr_resp_valid | output | 1 | Write response strobe |
| wr_status | output | 2 | 00 written, 01 protected, 10 out of range |
| rd_addr | input | 8 | Byte read address |
| rd_data | output | 8 | Byte read one cycle after the address |
| rd_err | output | 1 | Read address lies outside user memory |
| prot_map | output | 6 | Bit n set when block n is programmed |

## Verification
The bench builds the block with its defaults: six blocks of four bytes and 8-bit address and block-index fields. With 8-bit fields, the stimulus can reach block indices 6 through 255 and byte addresses 0x18 through 0xFF, so both out-of-range paths are exercised beside every real block and byte. Six blocks are few enough that random writes lock all of them early in the run. Most later writes then test the protected path, which checks that locked contents stay fixed through many refused attempts.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        WST_DONE   = 2'b00,
        WST_LOCKED = 2'b01,
        WST_RANGE  = 2'b10
    } wr_status_e;
endpackage

// File: rtl/otp_wr_ctrl.sv
module otp_wr_ctrl
    import otp_pkg::*;
#(
    parameter int NUM_BLOCKS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_blk,
    input  logic [NUM_BLOCKS-1:0] prot_i,
    output logic [NUM_BLOCKS-1:0] blk_we,
    output logic                  resp_valid,
    output wr_status_e            resp_status
);
    localparam logic [ADDR_W-1:0] LAST_BLK = ADDR_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic       valid;
        wr_status_e status;
    } resp_t;

    resp_t resp_d, resp_q;
    logic  in_range, locked;

    always_comb begin
        in_range = (req_blk <= LAST_BLK);
        locked   = 1'b0;
        blk_we   = '0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (req_blk == ADDR_W'(b)) begin
                locked = prot_i[b];
                blk_we[b] = req_valid && !prot_i[b];
            end
        end
        resp_d.valid  = req_valid;
        resp_d.status = resp_q.status;
        if (req_valid) begin
            if (!in_range)   resp_d.status = WST_RANGE;
            else if (locked) resp_d.status = WST_LOCKED;
            else             resp_d.status = WST_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '{valid: 1'b0, status: WST_DONE};
        else        resp_q <= resp_d;
    end

    assign resp_valid  = resp_q.valid;
    assign resp_status = resp_q.status;

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_we));
    p_range_nowe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_blk > LAST_BLK) |-> (blk_we == '0));
    p_locked_nowe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == WST_LOCKED) |-> $stable(prot_i));
endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int NUM_BLOCKS  = 6,
    parameter int BLOCK_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BLOCKS-1:0]           blk_we,
    input  logic [BLOCK_BYTES*8-1:0]        wdata,
    output logic [NUM_BLOCKS*BLOCK_BYTES*8-1:0] mem_flat,
    output logic [NUM_BLOCKS-1:0]           prot_o
);
    localparam int BLOCK_W = BLOCK_BYTES * 8;

    typedef struct packed {
        logic [NUM_BLOCKS-1:0][BLOCK_W-1:0] data;
        logic [NUM_BLOCKS-1:0]              prot;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (blk_we[b] && !st_q.prot[b]) begin
                st_d.data[b] = wdata;
                st_d.prot[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_flat = st_q.data;
    assign prot_o   = st_q.prot;

    p_prot_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(prot_o) & ~prot_o) == '0));

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock_chk
        p_locked_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(prot_o[g]) |-> $stable(mem_flat[g*BLOCK_W +: BLOCK_W]));
    end
endmodule

// File: rtl/otp_rd_port.sv
module otp_rd_port #(
    parameter int NUM_BLOCKS  = 6,
    parameter int BLOCK_BYTES = 4,
    parameter int ADDR_W      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_BLOCKS*BLOCK_BYTES*8-1:0] mem_flat,
    output logic [7:0]                          rd_data,
    output logic                                rd_err
);
    localparam int MEM_BYTES = NUM_BLOCKS * BLOCK_BYTES;

    typedef struct packed {
        logic [7:0] data;
        logic       err;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.data = 8'h00;
        rd_d.err  = 1'b1;
        for (int i = 0; i < MEM_BYTES; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_d.data = mem_flat[i*8 +: 8];
                rd_d.err  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;
    assign rd_err  = rd_q.err;

    p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 8'h00));
endmodule

// File: rtl/otp_block_mem.sv
module otp_block_mem
    import otp_pkg::*;
#(
    parameter int NUM_BLOCKS  = 6,
    parameter int BLOCK_BYTES = 4,
    parameter int ADDR_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_blk,
    input  logic [BLOCK_BYTES*8-1:0] wr_data,
    output logic                     wr_resp_valid,
    output logic [1:0]               wr_status,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     rd_err,
    output logic [NUM_BLOCKS-1:0]    prot_map
);
    localparam int MEM_W = NUM_BLOCKS * BLOCK_BYTES * 8;

    logic [NUM_BLOCKS-1:0] blk_we;
    logic [MEM_W-1:0]      mem_flat;
    wr_status_e            status_e;

    otp_wr_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .req_valid(wr_valid), .req_blk(wr_blk),
        .prot_i(prot_map), .blk_we(blk_we), .resp_valid(wr_resp_valid),
        .resp_status(status_e)
    );

    otp_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .wdata(wr_data),
        .mem_flat(mem_flat), .prot_o(prot_map)
    );

    otp_rd_port #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(rd_addr), .mem_flat(mem_flat),
        .rd_data(rd_data), .rd_err(rd_err)
    );

    assign wr_status = status_e;

    p_done_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_resp_valid && wr_status == 2'b00) |->
            ($countones(prot_map) == $countones($past(prot_map)) + 1));
    p_refused_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_resp_valid && wr_status != 2'b00) |-> $stable(prot_map));
    p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_resp_valid |-> (wr_status != 2'b11));
endmodule

// File: tb/otp_block_mem_test.sv
module otp_block_mem_test;
    localparam int NB = 6;
    localparam int MB = NB * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_blk = '0;
    logic [31:0] wr_data = '0;
    logic        wr_resp_valid;
    logic [1:0]  wr_status;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_err;
    logic [NB-1:0] prot_map;

    int checks = 0;
    int errors = 0;
    logic [7:0]    exp_mem [MB];
    logic [NB-1:0] exp_prot;

    always #10 clk = ~clk;

    otp_block_mem uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_blk(wr_blk),
        .wr_data(wr_data), .wr_resp_valid(wr_resp_valid), .wr_status(wr_status),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err), .prot_map(prot_map)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(input logic [7:0] blk);
        if (blk >= 8'(NB)) return 2'b10;
        if (exp_prot[blk[2:0]]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        if (a >= 8'(MB)) return 8'h00;
        return exp_mem[a[4:0]];
    endfunction

    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data == exp_byte(a), req, "rd_data", 32'(rd_data), 32'(exp_byte(a)));
        chk(rd_err == (a >= 8'(MB)), req, "rd_err", 32'(rd_err), 32'(a >= 8'(MB)));
    endtask

    task automatic do_write(input logic [7:0] blk, input logic [31:0] d, input string req);
        logic [1:0] es;
        @(negedge clk);
        es = exp_status(blk);
        wr_valid = 1'b1; wr_blk = blk; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_resp_valid == 1'b1, "R8", "resp_valid", 32'(wr_resp_valid), 32'd1);
        chk(wr_status == es, req, "wr_status", 32'(wr_status), 32'(es));
        if (es == 2'b00) begin
            for (int k = 0; k < 4; k++) exp_mem[blk*4 + k] = d[8*k +: 8];
            exp_prot[blk[2:0]] = 1'b1;
        end
        chk(prot_map == exp_prot, "R5", "prot_map", 32'(prot_map), 32'(exp_prot));
        @(negedge clk);
        chk(wr_resp_valid == 1'b0, "R8", "resp_valid drop", 32'(wr_resp_valid), 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MB; i++) exp_mem[i] = 8'h00;
        exp_prot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(prot_map == '0, "R1", "prot_map", 32'(prot_map), 32'd0);
        chk(wr_resp_valid == 1'b0, "R1", "resp_valid", 32'(wr_resp_valid), 32'd0);
        for (int a = 0; a < MB; a++) do_read(8'(a), "R1");
        // R3 boundaries
        do_read(8'h17, "R2");
        do_read(8'h18, "R3");
        do_read(8'hFF, "R3");
        // R4 byte order
        do_write(8'd0, 32'h44332211, "R4");
        for (int a = 0; a < 4; a++) do_read(8'(a), "R4");
        // R6 rewrite locked block
        do_write(8'd0, 32'hFFFFFFFF, "R6");
        for (int a = 0; a < 4; a++) do_read(8'(a), "R6");
        // R7 out of range indices
        do_write(8'd6, 32'hA5A5A5A5, "R7");
        do_write(8'd255, 32'h5A5A5A5A, "R7");
        // R9 all-zero write locks
        do_write(8'd5, 32'h00000000, "R9");
        do_write(8'd5, 32'hDEADBEEF, "R9");
        do_read(8'h14, "R9");
        do_read(8'h17, "R2");
        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 1) == 0) begin
                logic [31:0] d;
                d = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
                do_write(8'($urandom_range(0, 9)), d, "R6");
            end else begin
                logic [7:0] a;
                a = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(24, 255))
                                                : 8'($urandom_range(0, 31));
                do_read(a, "R2");
            end
        end
        for (int a = 0; a < MB; a++) do_read(8'(a), "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule